// File: doc/BRIEF.md
# Low-Power Standby Mode Controller

This controller moves a processor core between normal execution and three standby depths: a light halt, a deep hold and a crystal-hold. Each depth switches off its own set of clocks. The clocks are the CPU clock, the peripheral clock, the main crystal oscillator, the internal RC oscillator, the sub crystal oscillator and the base timer clock. Software asks for a depth through one of three request inputs.

Each depth also has its own list of events that bring the core back. The voltage-drop detector that counts differs between depths as well. The five external interrupt pins each have a programmable active level.

On leaving hold or crystal-hold, the oscillators that were stopped come back first. The CPU and peripheral clocks stay gated until a programmable number of sub-clock ticks has passed. The controller reports its current mode and a code for the highest-priority source that caused the last exit.

Top module: `stby_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller returns to mode RUN (code 0) and sets `wake_cause` to 1 (reset). In RUN the CPU, peripheral, main crystal, RC and base timer enables are all high, and `sxt_en` follows `sxt_run_en`.
- R2: In RUN, a request moves the controller at the next edge to HALT (1), HOLD (2) or crystal-hold XHOLD (3). If several requests are high together, the order is hold first, then crystal-hold, then halt.
- R3: In HALT only the CPU clock enable is low. The peripheral, main crystal, RC and base timer enables are high, and `sxt_en` follows `sxt_run_en`.
- R4: HALT returns to RUN at the next edge on any of these: `vdet0`, an active external pin, `p0_irq`, `bt_irq` or `per_irq`. `vdet1` alone has no effect in HALT.
- R5: In HOLD all six enables are low.
- R6: HOLD moves to the stabilisation mode WAKE (4) at the next edge on any of these: `vdet1`, an active external pin or `p0_irq`. `vdet0`, `bt_irq` and `per_irq` have no effect in HOLD.
- R7: In XHOLD the CPU, peripheral, main crystal and RC enables are low and the base timer enable is high. `sxt_en` keeps the value that `sxt_run_en` had at the entry edge, whatever `sxt_run_en` does later.
- R8: XHOLD moves to WAKE at the next edge on any of these: `vdet0`, an active external pin, `p0_irq` or `bt_irq`. `vdet1` and `per_irq` have no effect in XHOLD.
- R9: External pin i is active when `ext_irq[i]` equals `ext_pol[i]`. A level of 1 in `ext_pol` means active high.
- R10: In WAKE the main crystal, RC and base timer enables are high, `sxt_en` follows `sxt_run_en`, and the CPU and peripheral enables are low. The controller goes back to RUN at the first edge after `stab_count` `sub_tick` pulses have been counted in WAKE. With `stab_count` at 0, this is the first edge in WAKE.
- R11: At each exit edge `wake_cause` captures the code of the highest-priority source that the current mode honours: 2 voltage detector, 3 external pin, 4 port 0, 5 base timer, 6 other peripheral. It then holds that code until the next exit or reset.
- R12: Requests are ignored outside RUN. A standby mode is left only through its own wake sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Reset pin, synchronous, active low |
| req_halt | input | 1 | Software request for halt |
| req_hold | input | 1 | Software request for hold |
| req_xhold | input | 1 | Software request for crystal-hold |
| vdet0 | input | 1 | First voltage-drop detector flag |
| vdet1 | input | 1 | Second voltage-drop detector flag |
| ext_irq | input | N_EXT | External interrupt pin levels |
| ext_pol | input | N_EXT | Active level per external pin |
| p0_irq | input | 1 | Port-0 interrupt flag |
| bt_irq | input | 1 | Base timer interrupt flag |
| per_irq | input | 1 | Any other peripheral interrupt |
| sxt_run_en | input | 1 | Software setting of the sub crystal in RUN |
| sub_tick | input | 1 | One pulse per sub-clock cycle |
| stab_count | input | STAB_W | Sub-clock ticks to wait in WAKE |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mxt_en | output | 1 | Main crystal oscillator enable |
| rc_en | output | 1 | RC oscillator enable |
| sxt_en | output | 1 | Sub crystal oscillator enable |
| bt_clk_en | output | 1 | Base timer clock enable |
| mode | output | 3 | Current mode code |
| wake_cause | output | 3 | Code of the last exit source |

## Verification
The assertions assume a reset at the start of the run. They also assume that all inputs are synchronous to `clk` and change only between edges. The checker works out external-pin activity from `ext_irq` and `ext_pol` under the R9 rule, so it relies on the polarity being stable while a standby mode is held. The bench drives every input on the falling edge and sets polarity only before a reset. It keeps every inactive pin at the inverse of its active level, so a stray pin never looks active.

// File: rtl/stby_pkg.sv
// Shared mode and wake-cause codes and the clock-enable bundle of the
// standby controller. Assumes 3-bit codes are enough for both sets.
package stby_pkg;
    typedef enum logic [2:0] {
        MD_RUN   = 3'd0,
        MD_HALT  = 3'd1,
        MD_HOLD  = 3'd2,
        MD_XHOLD = 3'd3,
        MD_WAKE  = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        WC_NONE   = 3'd0,
        WC_RESET  = 3'd1,
        WC_VDET   = 3'd2,
        WC_EXT    = 3'd3,
        WC_PORT0  = 3'd4,
        WC_BTMR   = 3'd5,
        WC_PERIPH = 3'd6
    } cause_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic mxt;
        logic rc;
        logic sxt;
        logic bt;
    } clk_en_t;
endpackage

// File: rtl/stby_wake_sel.sv
// Wake-source filter and priority encoder. For the current mode it keeps
// only the sources that mode honours. It raises `wake` and gives the
// highest-priority cause code. Purely combinational. Assumes inputs are
// already synchronous to the controller clock.
module stby_wake_sel
    import stby_pkg::*;
#(
    parameter int N_EXT = 5
) (
    input  mode_e              mode,
    input  logic               vdet0,
    input  logic               vdet1,
    input  logic [N_EXT-1:0]   ext_irq,
    input  logic [N_EXT-1:0]   ext_pol,
    input  logic               p0_irq,
    input  logic               bt_irq,
    input  logic               per_irq,
    output logic               wake,
    output cause_e             cause
);
    logic [N_EXT-1:0] ext_hit;
    logic vd_sel, use_ext, use_p0, use_bt, use_per;
    logic src_vd, src_ext, src_p0, src_bt, src_per;

    // One level comparator per external pin: active when the level matches the polarity.
    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        assign ext_hit[g] = ~(ext_irq[g] ^ ext_pol[g]);
    end

    // Decide which sources the current mode listens to.
    always_comb begin
        vd_sel  = 1'b0;
        use_ext = 1'b0;
        use_p0  = 1'b0;
        use_bt  = 1'b0;
        use_per = 1'b0;
        unique case (mode)
            MD_HALT: begin
                vd_sel  = vdet0;
                use_ext = 1'b1;
                use_p0  = 1'b1;
                use_bt  = 1'b1;
                use_per = 1'b1;
            end
            MD_HOLD: begin
                vd_sel  = vdet1;
                use_ext = 1'b1;
                use_p0  = 1'b1;
            end
            MD_XHOLD: begin
                vd_sel  = vdet0;
                use_ext = 1'b1;
                use_p0  = 1'b1;
                use_bt  = 1'b1;
            end
            default: ;
        endcase
    end

    assign src_vd  = vd_sel;
    assign src_ext = use_ext & (|ext_hit);
    assign src_p0  = use_p0 & p0_irq;
    assign src_bt  = use_bt & bt_irq;
    assign src_per = use_per & per_irq;

    // Fixed priority: detector, external pins, port 0, base timer, peripheral.
    always_comb begin
        if (src_vd)       cause = WC_VDET;
        else if (src_ext) cause = WC_EXT;
        else if (src_p0)  cause = WC_PORT0;
        else if (src_bt)  cause = WC_BTMR;
        else if (src_per) cause = WC_PERIPH;
        else              cause = WC_NONE;
    end

    assign wake = src_vd | src_ext | src_p0 | src_bt | src_per;
endmodule

// File: rtl/stby_stab_cnt.sv
// Oscillator stabilisation counter. It counts sub-clock tick pulses while
// `clear` is low and saturates at `limit`. `done` is high once the count
// has reached the limit. Assumes `limit` is stable during a count.
module stby_stab_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Tick counter, cleared outside the stabilisation window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q >= limit);
endmodule

// File: rtl/stby_clk_gate.sv
// Decodes the controller mode into the six clock and oscillator enables.
// Assumes `sxt_keep` holds the sub crystal setting captured at
// crystal-hold entry.
module stby_clk_gate
    import stby_pkg::*;
(
    input  mode_e   mode,
    input  logic    sxt_run_en,
    input  logic    sxt_keep,
    output clk_en_t en
);
    // Enable pattern for each mode.
    always_comb begin
        en = '{cpu: 1'b1, per: 1'b1, mxt: 1'b1, rc: 1'b1, sxt: sxt_run_en, bt: 1'b1};
        unique case (mode)
            MD_RUN:   ;
            MD_HALT:  en.cpu = 1'b0;
            MD_HOLD:  en = '0;
            MD_XHOLD: en = '{cpu: 1'b0, per: 1'b0, mxt: 1'b0, rc: 1'b0, sxt: sxt_keep, bt: 1'b1};
            MD_WAKE: begin
                en.cpu = 1'b0;
                en.per = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stby_ctrl.sv
// Standby mode controller top. It holds the mode register, the latched
// wake cause and the sub crystal setting kept in crystal-hold. It takes
// software requests only in RUN and leaves each standby mode through the
// sources that mode honours. After a deep stop it passes through WAKE
// until the stabilisation count expires. Assumes all inputs are
// synchronous to clk. rst_n is the synchronous, active-low reset pin.
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int N_EXT  = 5,
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_halt,
    input  logic              req_hold,
    input  logic              req_xhold,
    input  logic              vdet0,
    input  logic              vdet1,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_EXT-1:0]  ext_pol,
    input  logic              p0_irq,
    input  logic              bt_irq,
    input  logic              per_irq,
    input  logic              sxt_run_en,
    input  logic              sub_tick,
    input  logic [STAB_W-1:0] stab_count,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              mxt_en,
    output logic              rc_en,
    output logic              sxt_en,
    output logic              bt_clk_en,
    output logic [2:0]        mode,
    output logic [2:0]        wake_cause
);
    mode_e   state_q;
    cause_e  cause_q;
    cause_e  wake_code;
    logic    sxt_keep_q;
    logic    wake_hit;
    logic    stab_done;
    clk_en_t en;

    stby_wake_sel #(.N_EXT(N_EXT)) u_wake (
        .mode    (state_q),
        .vdet0   (vdet0),
        .vdet1   (vdet1),
        .ext_irq (ext_irq),
        .ext_pol (ext_pol),
        .p0_irq  (p0_irq),
        .bt_irq  (bt_irq),
        .per_irq (per_irq),
        .wake    (wake_hit),
        .cause   (wake_code)
    );

    stby_stab_cnt #(.W(STAB_W)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != MD_WAKE),
        .tick  (sub_tick),
        .limit (stab_count),
        .done  (stab_done)
    );

    stby_clk_gate u_gate (
        .mode       (state_q),
        .sxt_run_en (sxt_run_en),
        .sxt_keep   (sxt_keep_q),
        .en         (en)
    );

    // Mode sequencer with wake-cause capture and sub crystal retention.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= MD_RUN;
            cause_q    <= WC_RESET;
            sxt_keep_q <= 1'b0;
        end else begin
            unique case (state_q)
                MD_RUN: begin
                    if (req_hold) begin
                        state_q <= MD_HOLD;
                    end else if (req_xhold) begin
                        state_q    <= MD_XHOLD;
                        sxt_keep_q <= sxt_run_en;
                    end else if (req_halt) begin
                        state_q <= MD_HALT;
                    end
                end
                MD_HALT: begin
                    if (wake_hit) begin
                        state_q <= MD_RUN;
                        cause_q <= wake_code;
                    end
                end
                MD_HOLD, MD_XHOLD: begin
                    if (wake_hit) begin
                        state_q <= MD_WAKE;
                        cause_q <= wake_code;
                    end
                end
                MD_WAKE: begin
                    if (stab_done) state_q <= MD_RUN;
                end
                default: state_q <= MD_RUN;
            endcase
        end
    end

    assign cpu_clk_en = en.cpu;
    assign per_clk_en = en.per;
    assign mxt_en     = en.mxt;
    assign rc_en      = en.rc;
    assign sxt_en     = en.sxt;
    assign bt_clk_en  = en.bt;
    assign mode       = state_q;
    assign wake_cause = cause_q;
endmodule

// File: rtl/stby_ctrl_chk.sv
// Property checker for the standby controller. It watches only the top
// ports and is attached to every instance by the bind below.
module stby_ctrl_chk #(
    parameter int N_EXT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vdet1,
    input logic [N_EXT-1:0] ext_irq,
    input logic [N_EXT-1:0] ext_pol,
    input logic             p0_irq,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             mxt_en,
    input logic             rc_en,
    input logic             sxt_en,
    input logic             bt_clk_en,
    input logic [2:0]       mode,
    input logic [2:0]       wake_cause
);
    logic no_ext_active;
    assign no_ext_active = &(ext_irq ^ ext_pol);

    a_r1_reset_run: assert property (@(posedge clk)
        !rst_n |=> (mode == 3'd0 && cpu_clk_en && per_clk_en && mxt_en && rc_en
                    && bt_clk_en && wake_cause == 3'd1));

    a_r3_halt_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd1 |-> (!cpu_clk_en && per_clk_en && mxt_en && rc_en && bt_clk_en));

    a_r5_hold_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd2 |-> !(cpu_clk_en || per_clk_en || mxt_en || rc_en || sxt_en || bt_clk_en));

    a_r7_xhold_sxt_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd3 |=> (mode != 3'd3 || $stable(sxt_en)));

    a_r7_xhold_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd3 |-> (!cpu_clk_en && !per_clk_en && !mxt_en && !rc_en && bt_clk_en));

    a_r10_wake_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd4 |-> (!cpu_clk_en && !per_clk_en && mxt_en && rc_en && bt_clk_en));

    a_r12_halt_exit: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd1 |=> (mode == 3'd1 || mode == 3'd0));

    a_r12_deep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 || mode == 3'd3) |=> (mode == $past(mode) || mode == 3'd4));

    a_r6_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && !vdet1 && !p0_irq && no_ext_active) |=> mode == 3'd2);
endmodule

bind stby_ctrl stby_ctrl_chk #(.N_EXT(N_EXT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vdet1      (vdet1),
    .ext_irq    (ext_irq),
    .ext_pol    (ext_pol),
    .p0_irq     (p0_irq),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .mxt_en     (mxt_en),
    .rc_en      (rc_en),
    .sxt_en     (sxt_en),
    .bt_clk_en  (bt_clk_en),
    .mode       (mode),
    .wake_cause (wake_cause)
);

// File: tb/stby_ctrl_tb.sv
// Self-checking bench: sweeps every mode against every single wake
// source under several pin polarities, then priority, request ordering,
// sub crystal retention and stabilisation counts.
module stby_ctrl_tb;
    localparam int N_EXT  = 5;
    localparam int STAB_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_halt = 0, req_hold = 0, req_xhold = 0;
    logic vdet0 = 0, vdet1 = 0, p0_irq = 0, bt_irq = 0, per_irq = 0;
    logic [N_EXT-1:0] ext_pol = '0;
    logic [N_EXT-1:0] ext_irq = '1;
    logic sxt_run_en = 1'b1;
    logic sub_tick = 1'b1;
    logic [STAB_W-1:0] stab_count = '0;
    logic cpu_clk_en, per_clk_en, mxt_en, rc_en, sxt_en, bt_clk_en;
    logic [2:0] mode, wake_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    stby_ctrl #(.N_EXT(N_EXT), .STAB_W(STAB_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_halt(req_halt), .req_hold(req_hold),
        .req_xhold(req_xhold), .vdet0(vdet0), .vdet1(vdet1), .ext_irq(ext_irq),
        .ext_pol(ext_pol), .p0_irq(p0_irq), .bt_irq(bt_irq), .per_irq(per_irq),
        .sxt_run_en(sxt_run_en), .sub_tick(sub_tick), .stab_count(stab_count),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .mxt_en(mxt_en),
        .rc_en(rc_en), .sxt_en(sxt_en), .bt_clk_en(bt_clk_en),
        .mode(mode), .wake_cause(wake_cause)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Enable vector {cpu,per,mxt,rc,sxt,bt} as an integer.
    function automatic int en_vec();
        return {cpu_clk_en, per_clk_en, mxt_en, rc_en, sxt_en, bt_clk_en};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {req_halt, req_hold, req_xhold, vdet0, vdet1, p0_irq, bt_irq, per_irq} = '0;
        ext_irq = ~ext_pol;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic enter(input int m);
        req_halt  = (m == 1);
        req_hold  = (m == 2);
        req_xhold = (m == 3);
        @(negedge clk);
        {req_halt, req_hold, req_xhold} = '0;
    endtask

    // Sources: 0 vdet0, 1 vdet1, 2..6 ext pin 0..4, 7 port0, 8 base timer, 9 peripheral.
    task automatic drive_src(input int src, input bit on);
        case (src)
            0: vdet0 = on;
            1: vdet1 = on;
            7: p0_irq = on;
            8: bt_irq = on;
            9: per_irq = on;
            default: ext_irq[src-2] = on ? ext_pol[src-2] : ~ext_pol[src-2];
        endcase
    endtask

    function automatic bit honours(input int m, input int src);
        case (m)
            1: return src != 1;
            2: return src >= 1 && src <= 7;
            default: return src == 0 || (src >= 2 && src <= 8);
        endcase
    endfunction

    function automatic int code_of(input int src);
        if (src <= 1) return 2;
        if (src <= 6) return 3;
        return src - 3;
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [N_EXT-1:0] pols [3];
        pols[0] = 5'b00000; pols[1] = 5'b11111; pols[2] = 5'b10110;

        // R1: reset state
        do_reset();
        check("R1 mode", mode, 0);
        check("R1 cause", wake_cause, 1);
        check("R1 enables", en_vec(), 6'b111111);
        sxt_run_en = 0;
        #1 check("R1 sxt follows", sxt_en, 0);
        sxt_run_en = 1;

        // R4 R6 R8 R9 R11: every mode against every single source and polarity
        for (int p = 0; p < 3; p++) begin
            for (int m = 1; m <= 3; m++) begin
                for (int src = 0; src < 10; src++) begin
                    ext_pol = pols[p];
                    do_reset();
                    enter(m);
                    check("R2 entry", mode, m);
                    drive_src(src, 1);
                    @(negedge clk);
                    drive_src(src, 0);
                    if (honours(m, src)) begin
                        check("R4 R6 R8 R9 wake mode", mode, (m == 1) ? 0 : 4);
                        check("R11 cause", wake_cause, code_of(src));
                    end else begin
                        check("R4 R6 R8 ignored", mode, m);
                        check("R11 cause held", wake_cause, 1);
                    end
                end
            end
        end
        ext_pol = '0;

        // R3 R5 R7: enables in each standby mode
        do_reset(); enter(1);
        check("R3 halt enables", en_vec(), 6'b011111);
        do_reset(); enter(2);
        check("R5 hold enables", en_vec(), 0);

        // R7: sub crystal retained at entry value both ways
        for (int v = 0; v < 2; v++) begin
            sxt_run_en = v[0];
            do_reset(); enter(3);
            check("R7 xhold enables", en_vec(), {4'b0000, v[0], 1'b1});
            sxt_run_en = ~v[0];
            repeat (3) @(negedge clk);
            check("R7 sxt kept", sxt_en, v);
        end
        sxt_run_en = 1;

        // R2: simultaneous requests
        for (int mask = 1; mask < 8; mask++) begin
            do_reset();
            req_halt = mask[0]; req_xhold = mask[1]; req_hold = mask[2];
            @(negedge clk);
            {req_halt, req_hold, req_xhold} = '0;
            check("R2 priority", mode, mask[2] ? 2 : (mask[1] ? 3 : 1));
        end

        // R12: requests ignored outside RUN
        for (int m = 1; m <= 3; m++) begin
            do_reset(); enter(m);
            {req_halt, req_hold, req_xhold} = 3'b111;
            repeat (2) @(negedge clk);
            {req_halt, req_hold, req_xhold} = '0;
            check("R12 no request", mode, m);
        end

        // R11: priority among sources in crystal-hold (vdet0, pin0, port0, base timer)
        for (int s = 1; s < 16; s++) begin
            do_reset(); enter(3);
            vdet0 = s[0]; ext_irq[0] = s[1] ? ext_pol[0] : ~ext_pol[0];
            p0_irq = s[2]; bt_irq = s[3];
            @(negedge clk);
            vdet0 = 0; ext_irq = ~ext_pol; p0_irq = 0; bt_irq = 0;
            check("R11 priority", wake_cause, s[0] ? 2 : s[1] ? 3 : s[2] ? 4 : 5);
        end
        do_reset(); enter(1);
        per_irq = 1; bt_irq = 1;
        @(negedge clk);
        per_irq = 0; bt_irq = 0;
        check("R11 bt over peripheral", wake_cause, 5);

        // R10: stabilisation length with a tick every cycle
        for (int n = 0; n < 6; n++) begin
            int k;
            stab_count = n[STAB_W-1:0];
            sub_tick = 1;
            do_reset(); enter(2);
            p0_irq = 1;
            @(negedge clk);
            p0_irq = 0;
            check("R10 wake entered", mode, 4);
            check("R10 wake enables", en_vec(), 6'b001111);
            k = 0;
            while (mode == 3'd4 && k < 50) begin
                @(negedge clk);
                k++;
            end
            check("R10 wake length", k, n + 1);
            check("R10 back to run", mode, 0);
        end

        // R10: no ticks means no progress
        begin
            int k;
            stab_count = 2;
            do_reset(); enter(3);
            sub_tick = 0;
            bt_irq = 1;
            @(negedge clk);
            bt_irq = 0;
            repeat (8) @(negedge clk);
            check("R10 waits for ticks", mode, 4);
            sub_tick = 1;
            k = 0;
            while (mode == 3'd4 && k < 50) begin
                @(negedge clk);
                k++;
            end
            check("R10 after ticks", k, 3);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule